// File: doc/BRIEF.md
# Triggerable Programmable Timer Unit

A single configurable down-counting timer intended to pace a serial shifter. It produces a timer output level, a shift-clock strobe chosen from that level or from one of its two inputs, a sticky compare flag and a trigger output toward a neighbouring timer. The counting runs in one of three variants: a full-width counter, a dual half-width baud counter (the low half sets the bit period, the high half counts output edges), and a dual half-width PWM counter (output high during the low half, low during the high half).

When the timer starts, when it stops, when its count is reloaded and what makes it count are each chosen by a select field. The sources are a trigger input and a pin input, each with its own inversion bit, taken as levels or edges. The timer can also follow the enable state or the disable event of the previous timer in a chain. An optional start period can be placed before the data periods, and an optional stop period can be inserted after a compare, before a disable, or both.

Top module: `trig_timer`

## Requirements
- R1: With `mode_sel` = 0 the timer never enables. If `mode_sel` becomes 0 while the timer runs, `trig_out` is 0 from the next cycle.
- R2: `trig_inv` inverts `trig_in` and `pin_inv` inverts `pin_in` before any level or edge is taken. All later rules use these conditioned values. Edges are taken against the value of the previous cycle, which reset clears to 0.
- R3: While disabled, `ena_sel` picks the start condition:
  - 0: always.
  - 1: `prev_en` high.
  - 2: trigger high.
  - 3: trigger high and pin high.
  - 4: pin rising.
  - 5: pin rising and trigger high.
  - 6: trigger rising.
  - 7: any trigger edge.
- R4: On the enabling edge the count loads `cmp_val`. `tmr_out` is forced to 1 for `out_sel` 0 or 2, and to 0 for `out_sel` 1 or 3.
- R5: With `mode_sel` = 3 (full width), each tick decrements the count. A tick at count 0 is a compare event: the count reloads and `tmr_out` toggles.
- R6: With `mode_sel` = 1 (baud), a tick while the low byte is 0 and the high byte is non-zero does three things: it reloads the low byte from `cmp_val`, decrements the high byte and toggles `tmr_out`. Any other non-compare tick decrements the low byte. A tick with both bytes 0 is a compare event: the count reloads and `tmr_out` toggles.
- R7: With `mode_sel` = 2 (PWM), a tick decrements the low byte while it is non-zero. Once the low byte is 0, a tick decrements the high byte and drives `tmr_out` to 0. A compare event (both bytes 0) reloads the count and drives `tmr_out` to 1.
- R8: `dec_sel` picks the tick and the `shift_clk` source:
  - 0: tick every cycle, `shift_clk` = `tmr_out`.
  - 1: tick on any trigger edge, `shift_clk` = `tmr_out`.
  - 2: tick on any pin edge, `shift_clk` = pin.
  - 3: tick on any trigger edge, `shift_clk` = trigger.
- R9: While running, and outside a stop period, `dis_sel` picks the stop condition:
  - 0 or 7: never.
  - 1: `prev_dis`.
  - 2: compare event.
  - 3: compare event with trigger low.
  - 4: any pin edge.
  - 5: any pin edge with trigger high.
  - 6: trigger falling.
  
  Without a stop-on-disable setting the timer turns off at once. A disable takes precedence over a reload.
- R10: `rst_sel` picks the reload condition:
  - 2: pin equals `tmr_out`.
  - 3: trigger equals `tmr_out`.
  - 4: pin rising.
  - 6: trigger rising.
  - 7: any trigger edge.
  - 0, 1 and 5: never.
  
  A reload sets the count to `cmp_val` and suppresses that cycle's tick and compare. It forces `tmr_out` to the R4 level only for `out_sel` 2 or 3.
- R11: With `start_en` = 1 the timer first runs one start period: the low byte (the whole count in full-width mode) counts to 0. The count then reloads, `tmr_out` toggles and normal counting begins. No compare event occurs during the start period.
- R12: `stop_sel` bit 0 inserts a stop period after each compare event. `stop_sel` bit 1 turns a disable event into a stop period that is followed by the disable. A stop period counts like a start period. It then resumes counting with a toggle, or disables with no toggle if a disable is pending. Disable events are ignored during a stop period.
- R13: `cmp_flag` sets on every compare event and stays set. `flag_clr` = 1 clears it on the next edge, but a compare event in the same cycle wins.
- R14: `trig_out` equals the timer's enabled state. Reset clears `trig_out`, `tmr_out` and `cmp_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Counting mode |
| cmp_val | input | CNT_W | Reload / compare value |
| ena_sel | input | 3 | Enable condition select |
| dis_sel | input | 3 | Disable condition select |
| rst_sel | input | 3 | Reload condition select |
| dec_sel | input | 2 | Tick and shift-clock source select |
| out_sel | input | 2 | Output level on enable / reload |
| start_en | input | 1 | Insert start period |
| stop_sel | input | 2 | Stop period on compare (bit 0) / on disable (bit 1) |
| trig_inv | input | 1 | Invert trigger input |
| pin_inv | input | 1 | Invert pin input |
| trig_in | input | 1 | Trigger input |
| pin_in | input | 1 | Pin input |
| prev_en | input | 1 | Enable state of previous timer |
| prev_dis | input | 1 | Disable event of previous timer |
| flag_clr | input | 1 | Write-one clear of compare flag |
| tmr_out | output | 1 | Timer output level |
| shift_clk | output | 1 | Shift clock for the shifter |
| cmp_flag | output | 1 | Sticky compare flag |
| trig_out | output | 1 | Trigger toward next timer (enabled state) |

## Verification
Most internal state here shows at the ports within a period. A wrong count reload or decrement moves the next `tmr_out` toggle by at least one tick. A wrong phase moves the first toggle or the point at which `trig_out` falls. A missed or extra compare event changes `cmp_flag` on the following edge. A mis-decoded condition changes `trig_out` or `tmr_out` one cycle after the qualifying edge, so a behavioural model compared on every cycle catches each fault within one timer period of where it first matters.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_BAUD = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_WIDE = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2,
    PH_STOP  = 2'd3
  } tmr_phase_e;

endpackage

// File: rtl/trig_timer_cond.sv
module trig_timer_cond (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic       pin_in,
  input  logic       trig_inv,
  input  logic       pin_inv,
  input  logic       prev_en,
  input  logic       tmr_out,
  input  logic [2:0] ena_sel,
  input  logic [2:0] rst_sel,
  input  logic [1:0] dec_sel,
  output logic       trg_lvl,
  output logic       trg_fall,
  output logic       pin_edge,
  output logic       ena_hit,
  output logic       rst_hit,
  output logic       tick,
  output logic       shift_clk
);

  logic trg_c, pin_c, trg_q, pin_q;
  logic trg_rise, trg_edge, pin_rise;

  // R2: polarity conditioning ahead of every level / edge use
  always_comb begin
    trg_c    = trig_in ^ trig_inv;
    pin_c    = pin_in ^ pin_inv;
    trg_rise = trg_c & ~trg_q;
    trg_fall = ~trg_c & trg_q;
    trg_edge = trg_c ^ trg_q;
    pin_rise = pin_c & ~pin_q;
    pin_edge = pin_c ^ pin_q;
    trg_lvl  = trg_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      trg_q <= trg_c;
      pin_q <= pin_c;
    end
  end

  // R3: enable condition
  always_comb begin
    case (ena_sel)
      3'd0:    ena_hit = 1'b1;
      3'd1:    ena_hit = prev_en;
      3'd2:    ena_hit = trg_c;
      3'd3:    ena_hit = trg_c & pin_c;
      3'd4:    ena_hit = pin_rise;
      3'd5:    ena_hit = pin_rise & trg_c;
      3'd6:    ena_hit = trg_rise;
      default: ena_hit = trg_edge;
    endcase
  end

  // R10: reload condition
  always_comb begin
    case (rst_sel)
      3'd2:    rst_hit = (pin_c == tmr_out);
      3'd3:    rst_hit = (trg_c == tmr_out);
      3'd4:    rst_hit = pin_rise;
      3'd6:    rst_hit = trg_rise;
      3'd7:    rst_hit = trg_edge;
      default: rst_hit = 1'b0;
    endcase
  end

  // R8: tick source and shift clock
  always_comb begin
    case (dec_sel)
      2'd0:    tick = 1'b1;
      2'd2:    tick = pin_edge;
      default: tick = trg_edge;
    endcase
    case (dec_sel)
      2'd2:    shift_clk = pin_c;
      2'd3:    shift_clk = trg_c;
      default: shift_clk = tmr_out;
    endcase
  end

  a_r8_free_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sel == 2'd2 && pin_c == pin_q) |-> !tick);

endmodule

// File: rtl/trig_timer_core.sv
module trig_timer_core
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       dis_sel,
  input  logic [1:0]       out_sel,
  input  logic             start_en,
  input  logic [1:0]       stop_sel,
  input  logic             prev_dis,
  input  logic             trg_lvl,
  input  logic             trg_fall,
  input  logic             pin_edge,
  input  logic             ena_hit,
  input  logic             rst_hit,
  input  logic             tick,
  output logic             en,
  output logic             out_lvl,
  output logic             cmp_evt
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] H_ONE = HALF_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  tmr_mode_e         mode;
  tmr_phase_e        ph_q, ph_d;
  logic              en_q, en_d, out_q, out_d, pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] lo, hi;
  logic              lo_zero, all_zero, seg_end, dis_dec, dis_hit, lvl;

  always_comb begin
    mode     = tmr_mode_e'(mode_sel);
    lo       = cnt_q[HALF_W-1:0];
    hi       = cnt_q[CNT_W-1:HALF_W];
    lo_zero  = (lo == '0);
    all_zero = (cnt_q == '0);
    seg_end  = (mode == MODE_WIDE) ? all_zero : lo_zero;
    lvl      = ~out_sel[0];
    cmp_evt  = en_q && (mode != MODE_OFF) && (ph_q == PH_RUN) && tick
               && all_zero && !rst_hit;
    // R9: disable condition
    case (dis_sel)
      3'd1:    dis_dec = prev_dis;
      3'd2:    dis_dec = cmp_evt;
      3'd3:    dis_dec = cmp_evt & ~trg_lvl;
      3'd4:    dis_dec = pin_edge;
      3'd5:    dis_dec = pin_edge & trg_lvl;
      3'd6:    dis_dec = trg_fall;
      default: dis_dec = 1'b0;
    endcase
    dis_hit = en_q && (ph_q != PH_STOP) && dis_dec;
  end

  always_comb begin
    en_d   = en_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    pend_d = pend_q;
    if (!en_q) begin
      if (mode != MODE_OFF && ena_hit) begin
        en_d   = 1'b1;
        cnt_d  = cmp_val;
        out_d  = lvl;
        pend_d = 1'b0;
        ph_d   = start_en ? PH_START : PH_RUN;
      end
    end else if (mode == MODE_OFF) begin
      en_d = 1'b0;
      ph_d = PH_IDLE;
    end else if (dis_hit) begin
      if (stop_sel[1]) begin
        ph_d   = PH_STOP;
        pend_d = 1'b1;
        cnt_d  = cmp_val;
      end else begin
        en_d = 1'b0;
        ph_d = PH_IDLE;
      end
    end else if (rst_hit) begin
      cnt_d = cmp_val;
      if (out_sel[1]) out_d = lvl;
    end else if (tick) begin
      if (ph_q == PH_START || ph_q == PH_STOP) begin
        if (!seg_end) begin
          cnt_d = cnt_q - C_ONE;
        end else if (ph_q == PH_STOP && pend_q) begin
          en_d   = 1'b0;
          ph_d   = PH_IDLE;
          pend_d = 1'b0;
        end else begin
          cnt_d = cmp_val;
          out_d = ~out_q;
          ph_d  = PH_RUN;
        end
      end else if (ph_q == PH_RUN) begin
        if (cmp_evt) begin
          cnt_d = cmp_val;
          out_d = (mode == MODE_PWM) ? 1'b1 : ~out_q;
          if (stop_sel[0]) ph_d = PH_STOP;
        end else if (mode == MODE_WIDE || !lo_zero) begin
          cnt_d = cnt_q - C_ONE;
        end else if (mode == MODE_BAUD) begin
          cnt_d = {hi - H_ONE, cmp_val[HALF_W-1:0]};
          out_d = ~out_q;
        end else begin
          cnt_d = {hi - H_ONE, lo};
          out_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      pend_q <= pend_d;
    end
  end

  assign en      = en_q;
  assign out_lvl = out_q;

  a_r1_off_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> !en_q);

  a_r4_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && ena_hit && mode != MODE_OFF) |=>
      (en_q && cnt_q == $past(cmp_val) && out_q == $past(~out_sel[0])));

  a_r11_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && ena_hit && mode != MODE_OFF) |=>
      (ph_q == ($past(start_en) ? PH_START : PH_RUN)));

  a_r12_stop_then_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode != MODE_OFF && ph_q == PH_STOP && pend_q && tick && seg_end && !rst_hit)
      |=> !en_q);

endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       ena_sel,
  input  logic [2:0]       dis_sel,
  input  logic [2:0]       rst_sel,
  input  logic [1:0]       dec_sel,
  input  logic [1:0]       out_sel,
  input  logic             start_en,
  input  logic [1:0]       stop_sel,
  input  logic             trig_inv,
  input  logic             pin_inv,
  input  logic             trig_in,
  input  logic             pin_in,
  input  logic             prev_en,
  input  logic             prev_dis,
  input  logic             flag_clr,
  output logic             tmr_out,
  output logic             shift_clk,
  output logic             cmp_flag,
  output logic             trig_out
);

  logic trg_lvl, trg_fall, pin_edge, ena_hit, rst_hit, tick;
  logic en, out_lvl, cmp_evt;
  logic flag_q, flag_d;

  trig_timer_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .pin_in    (pin_in),
    .trig_inv  (trig_inv),
    .pin_inv   (pin_inv),
    .prev_en   (prev_en),
    .tmr_out   (out_lvl),
    .ena_sel   (ena_sel),
    .rst_sel   (rst_sel),
    .dec_sel   (dec_sel),
    .trg_lvl   (trg_lvl),
    .trg_fall  (trg_fall),
    .pin_edge  (pin_edge),
    .ena_hit   (ena_hit),
    .rst_hit   (rst_hit),
    .tick      (tick),
    .shift_clk (shift_clk)
  );

  trig_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cmp_val  (cmp_val),
    .dis_sel  (dis_sel),
    .out_sel  (out_sel),
    .start_en (start_en),
    .stop_sel (stop_sel),
    .prev_dis (prev_dis),
    .trg_lvl  (trg_lvl),
    .trg_fall (trg_fall),
    .pin_edge (pin_edge),
    .ena_hit  (ena_hit),
    .rst_hit  (rst_hit),
    .tick     (tick),
    .en       (en),
    .out_lvl  (out_lvl),
    .cmp_evt  (cmp_evt)
  );

  // R13: sticky compare flag, set wins over clear
  always_comb begin
    flag_d = flag_q;
    if (cmp_evt)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cmp_flag = flag_q;
  assign tmr_out  = out_lvl;
  assign trig_out = en;     // R14

  a_r13_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag);

  a_r13_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_evt && flag_clr) |=> !cmp_flag);

endmodule

// File: tb/trig_timer_bench.sv
module trig_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int HSPAN      = 1 << (CNT_W / 2);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_sel, dec_sel, out_sel, stop_sel;
  logic [CNT_W-1:0] cmp_val;
  logic [2:0]       ena_sel, dis_sel, rst_sel;
  logic             start_en, trig_inv, pin_inv, trig_in, pin_in;
  logic             prev_en, prev_dis, flag_clr;
  logic             tmr_out, shift_clk, cmp_flag, trig_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R14";
  bit    done = 0;

  // reference model state
  int m_cnt, m_ph;
  bit m_en, m_out, m_pend, m_trgq, m_pinq, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_timer #(.CNT_W(CNT_W)) u_trig_timer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cmp_val(cmp_val),
    .ena_sel(ena_sel), .dis_sel(dis_sel), .rst_sel(rst_sel), .dec_sel(dec_sel),
    .out_sel(out_sel), .start_en(start_en), .stop_sel(stop_sel),
    .trig_inv(trig_inv), .pin_inv(pin_inv), .trig_in(trig_in), .pin_in(pin_in),
    .prev_en(prev_en), .prev_dis(prev_dis), .flag_clr(flag_clr),
    .tmr_out(tmr_out), .shift_clk(shift_clk), .cmp_flag(cmp_flag), .trig_out(trig_out)
  );

  task automatic model_step();
    bit trg, pin, tr, tf, te, pr, pe, tk, eh, rh, dd, dh, cmp, lvl, segend;
    int lo, hi;
    int n_cnt, n_ph;
    bit n_en, n_out, n_pend;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_en = 0; m_out = 0; m_pend = 0;
      m_trgq = 0; m_pinq = 0; m_flag = 0;
      return;
    end
    trg = trig_in ^ trig_inv;
    pin = pin_in ^ pin_inv;
    tr = trg && !m_trgq;  tf = !trg && m_trgq;  te = tr || tf;
    pr = pin && !m_pinq;  pe = pin != m_pinq;
    tk = (dec_sel == 0) ? 1 : (dec_sel == 2) ? pe : te;
    case (ena_sel)
      0: eh = 1;        1: eh = prev_en;   2: eh = trg;     3: eh = trg && pin;
      4: eh = pr;       5: eh = pr && trg; 6: eh = tr;      default: eh = te;
    endcase
    case (rst_sel)
      2: rh = (pin == m_out);  3: rh = (trg == m_out);
      4: rh = pr;  6: rh = tr;  7: rh = te;  default: rh = 0;
    endcase
    lo = m_cnt % HSPAN;
    hi = m_cnt / HSPAN;
    segend = (mode_sel == 3) ? (m_cnt == 0) : (lo == 0);
    cmp = m_en && mode_sel != 0 && m_ph == 2 && tk && m_cnt == 0 && !rh;
    case (dis_sel)
      1: dd = prev_dis;  2: dd = cmp;  3: dd = cmp && !trg;
      4: dd = pe;  5: dd = pe && trg;  6: dd = tf;  default: dd = 0;
    endcase
    dh  = m_en && m_ph != 3 && dd;
    lvl = !out_sel[0];
    n_cnt = m_cnt; n_ph = m_ph; n_en = m_en; n_out = m_out; n_pend = m_pend;
    if (!m_en) begin
      if (mode_sel != 0 && eh) begin
        n_en = 1; n_cnt = cmp_val; n_out = lvl; n_pend = 0;
        n_ph = start_en ? 1 : 2;
      end
    end else if (mode_sel == 0) begin
      n_en = 0; n_ph = 0;
    end else if (dh) begin
      if (stop_sel[1]) begin n_ph = 3; n_pend = 1; n_cnt = cmp_val; end
      else begin n_en = 0; n_ph = 0; end
    end else if (rh) begin
      n_cnt = cmp_val;
      if (out_sel[1]) n_out = lvl;
    end else if (tk) begin
      if (m_ph == 1 || m_ph == 3) begin
        if (!segend) n_cnt = m_cnt - 1;
        else if (m_ph == 3 && m_pend) begin n_en = 0; n_ph = 0; n_pend = 0; end
        else begin n_cnt = cmp_val; n_out = !m_out; n_ph = 2; end
      end else if (m_ph == 2) begin
        if (cmp) begin
          n_cnt = cmp_val;
          n_out = (mode_sel == 2) ? 1 : !m_out;
          if (stop_sel[0]) n_ph = 3;
        end else if (mode_sel == 3 || lo != 0) begin
          n_cnt = m_cnt - 1;
        end else if (mode_sel == 1) begin
          n_cnt = (hi - 1) * HSPAN + (cmp_val % HSPAN);
          n_out = !m_out;
        end else begin
          n_cnt = m_cnt - HSPAN;
          n_out = 0;
        end
      end
    end
    if (cmp) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    m_cnt = n_cnt; m_ph = n_ph; m_en = n_en; m_out = n_out; m_pend = n_pend;
    m_trgq = trg; m_pinq = pin;
  endtask

  task automatic check_bit(string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare against the model every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    model_step();
    #(CLK_PERIOD/4);
    if (!done) begin
      check_bit("trig_out", trig_out, m_en);
      check_bit("tmr_out", tmr_out, m_out);
      check_bit("cmp_flag", cmp_flag, m_flag);
      check_bit("shift_clk", shift_clk,
                (dec_sel < 2) ? m_out : (dec_sel == 2) ? (pin_in ^ pin_inv) : (trig_in ^ trig_inv));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic park();
    mode_sel = 2'd0; run(2);
    ena_sel = 0; dis_sel = 0; rst_sel = 0; dec_sel = 0; out_sel = 0;
    start_en = 0; stop_sel = 0; trig_inv = 0; pin_inv = 0;
    prev_en = 0; prev_dis = 0; flag_clr = 0;
  endtask

  task automatic flip_pin(int gap, int count);
    repeat (count) begin run(gap); pin_in = ~pin_in; end
  endtask

  task automatic flip_trig(int gap, int count);
    repeat (count) begin run(gap); trig_in = ~trig_in; end
  endtask

  initial begin
    rst_n = 0; mode_sel = 0; cmp_val = 0; ena_sel = 0; dis_sel = 0; rst_sel = 0;
    dec_sel = 0; out_sel = 0; start_en = 0; stop_sel = 0; trig_inv = 0; pin_inv = 0;
    trig_in = 0; pin_in = 0; prev_en = 0; prev_dis = 0; flag_clr = 0;
    cur_req = "R14"; run(3);                 // reset state
    rst_n = 1; run(1);

    cur_req = "R1";  cmp_val = 16'd3; run(5);   // mode 0 never enables
    cur_req = "R5";  mode_sel = 2'd3; run(25);
    cur_req = "R13"; flag_clr = 1; run(1); flag_clr = 0; run(3);
    flag_clr = 1; run(6); flag_clr = 0;
    cur_req = "R1";  mode_sel = 2'd0; run(3);
    park();

    cur_req = "R6";  cmp_val = 16'h0302; mode_sel = 2'd1; run(40); park();
    cur_req = "R7";  cmp_val = 16'h0203; out_sel = 2'd1; mode_sel = 2'd2; run(30); park();

    cur_req = "R8";  cmp_val = 16'd2; dec_sel = 2'd2; mode_sel = 2'd3;
    flip_pin(3, 10); park();
    cur_req = "R8";  cmp_val = 16'h0101; dec_sel = 2'd3; mode_sel = 2'd1;
    flip_trig(2, 12); dec_sel = 2'd1; flip_trig(2, 8); park();

    cur_req = "R2";  pin_inv = 1; ena_sel = 3'd4; cmp_val = 16'd4; mode_sel = 2'd3;
    run(3); pin_in = 1; run(3); pin_in = 0; run(6);
    trig_inv = 1; dis_sel = 3'd6; run(2); trig_in = 1; run(3); park();

    cur_req = "R3";  ena_sel = 3'd1; mode_sel = 2'd3; run(3); prev_en = 1; run(3); park();
    cur_req = "R3";  ena_sel = 3'd3; mode_sel = 2'd3; trig_in = 1; run(2); pin_in = 1; run(3); park();
    trig_in = 0; pin_in = 0; run(2);
    cur_req = "R3";  ena_sel = 3'd5; mode_sel = 2'd3; pin_in = 1; run(2); pin_in = 0; trig_in = 1; run(2);
    pin_in = 1; run(3); park();
    trig_in = 0; pin_in = 0;
    cur_req = "R3";  ena_sel = 3'd7; mode_sel = 2'd3; run(2); trig_in = 1; run(2); park();
    cur_req = "R3";  ena_sel = 3'd6; mode_sel = 2'd3; run(2); trig_in = 0; run(2); trig_in = 1; run(3); park();
    cur_req = "R3";  ena_sel = 3'd2; mode_sel = 2'd3; run(3); park();
    trig_in = 0;

    cur_req = "R9";  cmp_val = 16'd3; dis_sel = 3'd2; mode_sel = 2'd3; run(12); park();
    cur_req = "R9";  dis_sel = 3'd3; trig_in = 1; mode_sel = 2'd3; run(8); trig_in = 0; run(6); park();
    cur_req = "R9";  dis_sel = 3'd4; mode_sel = 2'd3; run(3); pin_in = ~pin_in; run(3); park();
    cur_req = "R9";  dis_sel = 3'd5; mode_sel = 2'd3; run(2); pin_in = ~pin_in; run(2);
    trig_in = 1; run(2); pin_in = ~pin_in; run(3); park();
    trig_in = 0;
    cur_req = "R9";  dis_sel = 3'd1; mode_sel = 2'd3; run(3); prev_dis = 1; run(1); prev_dis = 0; run(2); park();

    cur_req = "R10"; cmp_val = 16'd5; rst_sel = 3'd6; out_sel = 2'd2; mode_sel = 2'd3;
    flip_trig(3, 8); park();
    cur_req = "R10"; rst_sel = 3'd7; out_sel = 2'd1; mode_sel = 2'd3; flip_trig(4, 6); park();
    cur_req = "R10"; rst_sel = 3'd4; out_sel = 2'd3; mode_sel = 2'd3; flip_pin(3, 8); park();
    cur_req = "R10"; rst_sel = 3'd2; mode_sel = 2'd3; run(4); pin_in = ~pin_in; run(10); park();
    cur_req = "R10"; rst_sel = 3'd3; mode_sel = 2'd3; run(4); trig_in = ~trig_in; run(10); park();
    trig_in = 0; pin_in = 0;

    cur_req = "R11"; cmp_val = 16'h0103; start_en = 1; mode_sel = 2'd1; run(30); park();
    cur_req = "R11"; cmp_val = 16'd4; start_en = 1; mode_sel = 2'd3; run(20); park();

    cur_req = "R12"; cmp_val = 16'd2; stop_sel = 2'd1; mode_sel = 2'd3; run(20); park();
    cur_req = "R12"; cmp_val = 16'd2; stop_sel = 2'd2; dis_sel = 3'd2; mode_sel = 2'd3; run(14); park();
    cur_req = "R12"; cmp_val = 16'h0102; stop_sel = 2'd3; dis_sel = 3'd4; mode_sel = 2'd1;
    run(5); pin_in = ~pin_in; run(2); pin_in = ~pin_in; run(10); park();

    cur_req = "R13"; cmp_val = 16'd1; flag_clr = 1; mode_sel = 2'd3; run(10); flag_clr = 0; park();

    cur_req = "R14"; rst_n = 0; run(2); rst_n = 1; run(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule